// File: doc/BRIEF.md
# Three-group carry-skip adder

This block adds two unsigned operands and a carry-in, and returns the sum and the carry-out. To shorten the worst-case carry path, it splits the operand into three contiguous groups. The lowest and highest groups are plain ripple-carry chains. The middle group also ripples internally, and it additionally forms a group propagate term. When every bit of the middle group would pass a carry through, a multiplexer forwards the carry entering that group straight to the high group. The carry then does not travel through the middle group's bits.

Each bit position has exactly one sum cell and one carry cell. The skip path adds only one AND tree and one two-input multiplexer. The default group split is 5/6/5 for a 16-bit adder and 10/12/10 for a 32-bit adder. The split can be overridden through parameters, and an elaboration check rejects any split whose sizes do not add up to the width. An output register stage, enabled by default, retimes the result onto the clock.

Top module: `csk_adder3`

## Requirements
- R1: With the output stage enabled, `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` sampled at the previous rising clock edge, for every input combination.
- R2: With WIDTH=16 the default groups are 5, 6 and 5 bits from least significant upward; with WIDTH=32 they are 10, 12 and 10. Both widths produce exact sums.
- R3: The carry passed from the low group into the middle group equals bit LO_W of the sum of the low LO_W bits of both operands plus `cin_i`.
- R4: When every bit of the middle group has `a XOR b = 1`, the middle group's carry-out equals its carry-in. For example, a = all ones, b = 0 and cin = 1 gives sum 0 with carry-out 1.
- R5: When at least one middle bit does not propagate, the middle group's carry-out equals the carry out of the top bit of that group's own ripple chain.
- R6: `cout_o` equals bit WIDTH of the full-width sum `a_i + b_i + cin_i` from the same sampled inputs.
- R7: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears `sum_o` and `cout_o` to zero at that edge, whatever the operands are.
- R8: A carry generated inside any one group (a bit with a = b = 1) reaches every higher bit and `cout_o` correctly, including carries that start in the middle group and carries that start in the high group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, registered when OUT_REG=1 |
| cout_o | output | 1 | Carry out of the top bit, registered when OUT_REG=1 |

## Verification
With the default output stage, the adder's data path is combinational up to a single register. Sum and carry-out are therefore both due at the first rising edge after the operands are applied, and the reset clear is due at the edge that samples `rst_n` low. The bench changes operands on a falling edge and reads both outputs on the next falling edge, half a period after the register has loaded. This gives exactly one cycle of latency per vector. The checker compares the registered result with the operands of the previous edge. It also compares the carries between groups with slice-wise arithmetic in the same cycle the operands are present.

// File: rtl/csk_pkg.sv
// Package csk_pkg
// Shared helpers for the three-group carry-skip adder: default group sizing
// and single-bit full-adder equations. Assumes widths of at least 3 bits.
package csk_pkg;

    // Default size of the least significant group for a given width.
    function automatic int lo_default(input int width);
        if (width == 16) return 5;
        if (width == 32) return 10;
        return (width * 5) / 16;
    endfunction

    // Default size of the middle (skippable) group for a given width.
    function automatic int mid_default(input int width);
        if (width == 16) return 6;
        if (width == 32) return 12;
        return width - 2 * ((width * 5) / 16);
    endfunction

    // Sum output of one full-adder cell.
    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    // Carry output of one full-adder cell.
    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x ^ y));
    endfunction

endpackage

// File: rtl/csk_ripple_group.sv
// Module csk_ripple_group
// Plain ripple-carry chain of GW full-adder cells. Used for the low and high
// groups, and as the internal chain of the middle group. Assumes GW >= 1.
module csk_ripple_group #(
    parameter int GW = 5
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          cout_o
);
    import csk_pkg::*;

    logic [GW:0] chain;

    // Carry enters the chain at its bottom.
    assign chain[0] = cin_i;

    genvar k;
    generate
        for (k = 0; k < GW; k++) begin : g_cell
            // One full-adder cell per bit position.
            assign sum_o[k]     = fa_sum(a_i[k], b_i[k], chain[k]);
            assign chain[k + 1] = fa_carry(a_i[k], b_i[k], chain[k]);
        end
    endgenerate

    // Carry leaving the top cell.
    assign cout_o = chain[GW];

endmodule

// File: rtl/csk_skip_group.sv
// Module csk_skip_group
// Middle group: an internal ripple chain for the sum bits, plus a group
// propagate term that selects the incoming carry as the group carry-out when
// every bit would pass it through. Sum bits are always taken from the chain.
module csk_skip_group #(
    parameter int GW = 6
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          cout_o,
    output logic          prop_o
);
    logic [GW-1:0] bit_prop;
    logic          ripple_cout;

    // The internal chain produces every sum bit of the group.
    csk_ripple_group #(.GW(GW)) u_chain (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (cin_i),
        .sum_o (sum_o),
        .cout_o(ripple_cout)
    );

    // Per-bit propagate terms.
    assign bit_prop = a_i ^ b_i;

    // Group propagate: every bit would pass a carry through.
    assign prop_o = &bit_prop;

    // Skip multiplexer: bypass the chain when the group fully propagates.
    always_comb begin
        if (prop_o) cout_o = cin_i;
        else        cout_o = ripple_cout;
    end

endmodule

// File: rtl/csk_out_stage.sv
// Module csk_out_stage
// Optional retiming stage on the adder result. OUT_REG=1 gives one register
// with synchronous active-low clear; OUT_REG=0 passes the result straight on.
module csk_out_stage #(
    parameter int DW      = 17,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);
    generate
        if (OUT_REG) begin : g_reg
            logic [DW-1:0] q_r;
            // Load the result each edge, clearing it under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_comb
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/csk_adder3.sv
// Module csk_adder3
// Three-group carry-skip adder. The low and high groups ripple; the middle group
// ripples internally and carries a skip multiplexer on its carry-out. The
// group sizes must sum to WIDTH; this is checked at elaboration.
module csk_adder3 #(
    parameter int WIDTH   = 16,
    parameter int LO_W    = csk_pkg::lo_default(WIDTH),
    parameter int MID_W   = csk_pkg::mid_default(WIDTH),
    parameter int HI_W    = WIDTH - LO_W - MID_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int MID_LSB = LO_W;
    localparam int HI_LSB  = LO_W + MID_W;
    localparam int RES_W   = WIDTH + 1;

    // Elaboration check on the group split.
    generate
        if (LO_W + MID_W + HI_W != WIDTH || LO_W < 1 || MID_W < 1 || HI_W < 1) begin : g_bad_split
            $error("csk_adder3: group sizes do not form a valid split of WIDTH");
        end
    endgenerate

    logic [LO_W-1:0]  lo_sum;
    logic [MID_W-1:0] mid_sum;
    logic [HI_W-1:0]  hi_sum;
    logic             lo_cout;
    logic             mid_cout;
    logic             mid_prop;
    logic             hi_cout;
    logic [RES_W-1:0] result;
    logic [RES_W-1:0] result_q;

    // Low group: plain ripple chain fed by the adder carry-in.
    csk_ripple_group #(.GW(LO_W)) u_lo (
        .a_i   (a_i[LO_W-1:0]),
        .b_i   (b_i[LO_W-1:0]),
        .cin_i (cin_i),
        .sum_o (lo_sum),
        .cout_o(lo_cout)
    );

    // Middle group: ripple chain with a skip multiplexer on its carry-out.
    csk_skip_group #(.GW(MID_W)) u_mid (
        .a_i   (a_i[MID_LSB +: MID_W]),
        .b_i   (b_i[MID_LSB +: MID_W]),
        .cin_i (lo_cout),
        .sum_o (mid_sum),
        .cout_o(mid_cout),
        .prop_o(mid_prop)
    );

    // High group: plain ripple chain fed by the skip multiplexer.
    csk_ripple_group #(.GW(HI_W)) u_hi (
        .a_i   (a_i[HI_LSB +: HI_W]),
        .b_i   (b_i[HI_LSB +: HI_W]),
        .cin_i (mid_cout),
        .sum_o (hi_sum),
        .cout_o(hi_cout)
    );

    // Assemble carry-out and sum into one result word.
    assign result = {hi_cout, hi_sum, mid_sum, lo_sum};

    // Optional register stage on the result.
    csk_out_stage #(.DW(RES_W), .OUT_REG(OUT_REG)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (result),
        .q_o  (result_q)
    );

    assign sum_o  = result_q[WIDTH-1:0];
    assign cout_o = result_q[WIDTH];

endmodule

// File: rtl/csk_adder3_chk.sv
// Module csk_adder3_chk
// Assertion checker bound into csk_adder3. It compares the group carries and
// the output with slice-wise arithmetic on the operands.
module csk_adder3_chk #(
    parameter int WIDTH   = 16,
    parameter int LO_W    = 5,
    parameter int MID_W   = 6,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic             lo_cout,
    input logic             mid_cout,
    input logic             mid_prop
);
    logic [WIDTH:0] full_ref;
    logic [LO_W:0]  lo_ref;
    logic [MID_W:0] mid_ref;

    // Arithmetic references for the whole word and for the lower two slices.
    assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    assign lo_ref   = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
    assign mid_ref  = {1'b0, a_i[LO_W +: MID_W]} + {1'b0, b_i[LO_W +: MID_W]} + {{MID_W{1'b0}}, lo_cout};

    p_lo_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cout == lo_ref[LO_W]);

    p_skip_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mid_prop |-> (mid_cout == lo_cout));

    p_noskip_ripple_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_prop |-> (mid_cout == mid_ref[MID_W]));

    generate
        if (OUT_REG) begin : g_seq
            p_sum_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (sum_o == $past(full_ref[WIDTH-1:0])));

            p_cout_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (cout_o == $past(full_ref[WIDTH])));

            p_reset_clear_r7: assert property (@(posedge clk)
                !rst_n |=> (sum_o == '0 && cout_o == 1'b0));
        end else begin : g_cmb
            p_sum_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
                sum_o == full_ref[WIDTH-1:0]);

            p_cout_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
                cout_o == full_ref[WIDTH]);
        end
    endgenerate

endmodule

bind csk_adder3 csk_adder3_chk #(
    .WIDTH  (WIDTH),
    .LO_W   (LO_W),
    .MID_W  (MID_W),
    .OUT_REG(OUT_REG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .lo_cout (lo_cout),
    .mid_cout(mid_cout),
    .mid_prop(mid_prop)
);

// File: tb/csk_adder3_test.sv
// Bench for csk_adder3: a 16-bit instance driven from a vector table, random
// operands at 16 and 32 bits, then directed reset and group-boundary cases.
module csk_adder3_test;

    localparam int  NV          = 12;
    localparam time WATCHDOG_NS = 1ms;

    logic        clk;
    logic        rst_n;
    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    int checks;
    int errors;

    // Each entry: {a[49:34], b[33:18], cin[17], expected {cout,sum}[16:0]}.
    localparam logic [49:0] VEC16 [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h0_0000},  // R7 quiet operands
        {16'hFFFF, 16'h0000, 1'b1, 17'h1_0000},  // R4 full propagate
        {16'hFFFF, 16'h0001, 1'b0, 17'h1_0000},  // R4 generate at bit 0
        {16'h001F, 16'h0001, 1'b0, 17'h0_0020},  // R3 low group carry out
        {16'h07FF, 16'h0001, 1'b0, 17'h0_0800},  // R4 skip middle group
        {16'hF800, 16'h0800, 1'b0, 17'h1_0000},  // R8 generate in high group
        {16'h0400, 16'h0400, 1'b0, 17'h0_0800},  // R8 generate in middle group
        {16'h1234, 16'h4321, 1'b0, 17'h0_5555},  // R5 no carry at all
        {16'h8000, 16'h8000, 1'b1, 17'h1_0001},  // R6 carry out of top bit
        {16'hABCD, 16'h5432, 1'b1, 17'h1_0000},  // R4 all propagate via mix
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1_FFFF},  // R8 all generate
        {16'h0010, 16'h0010, 1'b1, 17'h0_0021}   // R3 generate at bit 4
    };

    csk_adder3 uut (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a16),
        .b_i   (b16),
        .cin_i (c16),
        .sum_o (s16),
        .cout_o(co16)
    );

    csk_adder3 #(.WIDTH(32)) uut_w32 (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a32),
        .b_i   (b32),
        .cin_i (c32),
        .sum_o (s32),
        .cout_o(co32)
    );

    // 100 MHz clock.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk16(input string tag, input logic [16:0] exp);
        checks++;
        if ({co16, s16} !== exp) begin
            errors++;
            $display("FAIL %s 16-bit: actual %h expected %h", tag, {co16, s16}, exp);
        end
    endtask

    task automatic chk32(input string tag, input logic [32:0] exp);
        checks++;
        if ({co32, s32} !== exp) begin
            errors++;
            $display("FAIL %s 32-bit: actual %h expected %h", tag, {co32, s32}, exp);
        end
    endtask

    // Drive on a falling edge, check one falling edge later (one register).
    task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(negedge clk);
        a16 = a; b16 = b; c16 = c;
        @(negedge clk);
    endtask

    task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        a32 = a; b32 = b; c32 = c;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(WATCHDOG_NS);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        checks = 0;
        errors = 0;
        rst_n  = 1'b0;
        a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1;
        a32 = 32'hFFFF_FFFF; b32 = 32'hFFFF_FFFF; c32 = 1'b1;
        repeat (3) @(negedge clk);
        // R7: reset clears outputs despite nonzero operands.
        chk16("R7 reset state", 17'h0);
        chk32("R7 reset state", 33'h0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R8: table walk at 16 bits (5/6/5 split).
        for (int i = 0; i < NV; i++) begin
            apply16(VEC16[i][49:34], VEC16[i][33:18], VEC16[i][17]);
            chk16($sformatf("R1 R2 R6 vector %0d", i), VEC16[i][16:0]);
        end

        // R1 R6: random operands at 16 bits.
        for (int i = 0; i < 300; i++) begin
            logic [15:0] ra, rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            apply16(ra, rb, rc);
            chk16("R1 R6 random", {1'b0, ra} + {1'b0, rb} + {16'h0, rc});
        end

        // R2: random operands at 32 bits (10/12/10 split).
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            logic        rc;
            ra = $urandom;
            rb = $urandom;
            rc = 1'($urandom);
            apply32(ra, rb, rc);
            chk32("R2 R1 random", {1'b0, ra} + {1'b0, rb} + {32'h0, rc});
        end

        // R4: full propagate through all groups at 32 bits.
        apply32(32'hFFFF_FFFF, 32'h0, 1'b1);
        chk32("R4 full propagate", 33'h1_0000_0000);
        // R4: low group generates, middle group (bits 10..21) skipped.
        apply32(32'h003F_FFFF, 32'h0000_0001, 1'b0);
        chk32("R4 middle skip", 33'h0_0040_0000);
        // R5: middle not propagating, carry generated at its top bit.
        apply32(32'h0020_0000, 32'h0020_0000, 1'b0);
        chk32("R5 middle top generate", 33'h0_0040_0000);
        // R3: carry out of low group at bit 9 into middle.
        apply32(32'h0000_03FF, 32'h0000_0000, 1'b1);
        chk32("R3 low carry", 33'h0_0000_0400);
        // R8: carry generated in high group leaves as carry-out.
        apply32(32'h8000_0000, 32'h8000_0000, 1'b0);
        chk32("R8 high generate", 33'h1_0000_0000);

        // R7: reset mid-run clears outputs at the sampling edge.
        @(negedge clk);
        a16 = 16'h7777; b16 = 16'h1111; c16 = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk16("R7 mid-run reset", 17'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk16("R7 after release", 17'h0_8889);

        report();
        $finish;
    end

endmodule